// File: doc/BRIEF.md
# Periodic Wakeup Auto-Reload Timer

This block counts timer ticks downward from a programmed reload value and raises a sticky wakeup flag each time the count passes zero. The count then restarts from the reload value with no lost tick. A 3-bit tick-select field picks the tick source. Four codes take a free-running power-of-two division of the block clock. The remaining codes take an external once-per-second tick-enable input, and in that mode the counter grows by one bit. Software clears the flag with a one-cycle strobe. An interrupt output follows the flag when the interrupt enable is set.

Configuration arrives through simple write strobes. One strobe carries the control fields: run enable, tick select and interrupt enable. A second strobe carries the reload value. The reload value and the tick select only change while the write-allowed output is high, which is the case whenever the timer is stopped. A three-state machine tracks the timer. IDLE is stopped and writable. RUN is counting. DRAIN is stopped but still locked, waiting for a tick. The transitions are IDLE to RUN on an enabling control write, RUN to DRAIN on a disabling control write, and DRAIN to IDLE on the next tick.

Top module: `wkup_timer`

## Requirements
- R1: After reset the reload value reads 0x0000FFFF on the 32-bit readback with bits 31:16 always zero. Tick select is 3'b000, the timer is stopped, write-allowed is 1, and the flag and the interrupt are 0.
- R2: Tick select 3'b000, 3'b001, 3'b010 and 3'b011 give one tick every 16, 8, 4 and 2 clock cycles of a free-running prescaler. Any select with bit 2 set uses each clock cycle on which `sec_tick` is high as one tick.
- R3: While running, the flag is set once every (reload + 1) ticks without drift. The count reloads on the tick that finds it at zero, and the flag is set on that same tick.
- R4: The first flag comes on exactly the (reload + 1)-th tick after the clock edge that captures the enabling control write. A tick present in that same cycle is not counted.
- R5: With tick select bit 2 set, the counter is 17 bits wide and is loaded with {select bit 1, reload}. Select 3'b110 with reload 2 therefore gives a first flag after 65539 ticks, and select 3'b100 with reload 2 gives it after 3 ticks.
- R6: Write-allowed is 0 from the edge that captures an enabling control write until the timer is stopped again. A reload write made while write-allowed is 0 leaves the reload value unchanged.
- R7: A disabling control write stops the counter, and no further flag is set. Write-allowed returns to 1 on the first tick after that write. An enabling write made before then is ignored, and a tick-select change made while write-allowed is 0 is ignored.
- R8: The pairing of reload 0x0000 with tick select 3'b011 is refused. A reload write of 0 while the select is 3'b011 is dropped. A control write that requests select 3'b011 while the reload is 0 keeps the old select.
- R9: The flag stays set until `flag_clr` is pulsed. If a period expires on the same edge as the clear, the flag stays set.
- R10: `irq` is 1 exactly when the flag is set and the interrupt enable is 1. The interrupt enable may be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | Once-per-second tick enable used when select bit 2 is set |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Run enable value for a control write |
| ctrl_sel | input | 3 | Tick select value for a control write |
| ctrl_ie | input | 1 | Interrupt enable value for a control write |
| rld_we | input | 1 | Reload write strobe |
| rld_wdata | input | 16 | Reload value for a reload write |
| flag_clr | input | 1 | Wakeup flag clear strobe |
| rld_rdata | output | 32 | Reload value readback, upper bits zero |
| sel_rdata | output | 3 | Current tick select |
| running | output | 1 | High while the state is RUN |
| wr_ok | output | 1 | High while reload and tick select may be written |
| wake_flag | output | 1 | Sticky wakeup flag |
| irq | output | 1 | Wakeup interrupt |

## Verification
The steady period is swept over every clock-divided select crossed with reload values 0 to 3, skipping only the refused pairing. The spacing of successive flags, equal to (reload+1) times the division, separates a wrong divider from an off-by-one in the reload path. The once-per-second mode is driven with sparse pulses and with a tick in the enable cycle, which pins the first flag to an exact tick count. A long continuous-tick run tells the 17-bit extension apart from the 16-bit count. Separate sequences cover writes while locked, the DRAIN exit, clear-versus-set collisions and both halves of the refused pairing.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } wkt_state_e;

    localparam int          DIV_CNT   = 4;
    localparam logic [2:0]  SEL_DIV2  = 3'b011;
    localparam int          RDATA_W   = 32;
endpackage

// File: rtl/wkt_prescale.sv
module wkt_prescale #(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       sec_tick,
    output logic       tick
);
    import wkt_pkg::*;

    logic [PRE_W-1:0]   pre_q;
    logic [DIV_CNT-1:0] div_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PRE_W'(1);
    end

    // code i divides by 2**(PRE_W-i): all low bits of the prescaler at one
    for (genvar i = 0; i < DIV_CNT; i++) begin : g_div
        assign div_tick[i] = &pre_q[PRE_W-1-i:0];
    end

    always_comb begin
        if (sel[2]) tick = sec_tick;
        else        tick = div_tick[sel[1:0]];
    end

    // R2: the divide-by-two tick alternates
    a_r2_div2_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DIV2 && tick) |=> (sel != SEL_DIV2 || !tick));
endmodule

// File: rtl/wkt_ctrl.sv
module wkt_ctrl #(
    parameter int RLD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic [2:0]       ctrl_sel,
    input  logic             ctrl_ie,
    input  logic             rld_we,
    input  logic [RLD_W-1:0] rld_wdata,
    output logic [2:0]       sel_q,
    output logic             ie_q,
    output logic [RLD_W-1:0] rld_q,
    output logic             run,
    output logic             wr_ok,
    output logic             load,
    output logic [RLD_W:0]   load_val,
    output logic [RLD_W:0]   reload_val
);
    import wkt_pkg::*;

    wkt_state_e       state_q, state_nx;
    logic             rld_acc, sel_acc;
    logic [RLD_W-1:0] rld_nx;
    logic [2:0]       sel_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (ctrl_we && ctrl_en)  state_nx = ST_RUN;
            ST_RUN:   if (ctrl_we && !ctrl_en) state_nx = ST_DRAIN;
            ST_DRAIN: if (tick)                state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        wr_ok = 1'b0;
        run   = 1'b0;
        load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_ok = 1'b1;
                load  = ctrl_we && ctrl_en;
            end
            ST_RUN:   run = 1'b1;
            ST_DRAIN: ;
            default:  ;
        endcase
    end

    // configuration acceptance, refusing the forbidden pairing
    always_comb begin
        rld_acc  = rld_we && wr_ok && !((rld_wdata == '0) && (sel_q == SEL_DIV2));
        rld_nx   = rld_acc ? rld_wdata : rld_q;
        sel_acc  = ctrl_we && wr_ok && !((ctrl_sel == SEL_DIV2) && (rld_nx == '0));
        sel_nx   = sel_acc ? ctrl_sel : sel_q;
        load_val   = {sel_nx[2] & sel_nx[1], rld_nx};
        reload_val = {sel_q[2] & sel_q[1], rld_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= '1;
            sel_q <= 3'b000;
            ie_q  <= 1'b0;
        end else begin
            rld_q <= rld_nx;
            sel_q <= sel_nx;
            if (ctrl_we) ie_q <= ctrl_ie;
        end
    end

    // R6: reload frozen while not writable
    a_r6_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(rld_q));
    // R7: tick select frozen while not writable
    a_r7_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(sel_q));
    // R8: the refused pairing never held
    a_r8_no_forbidden: assert property (@(posedge clk) disable iff (!rst_n)
        !((sel_q == SEL_DIV2) && (rld_q == '0)));
    // R6: an enabling write from IDLE starts the run
    a_r6_enable_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_we && ctrl_en) |=> (state_q == ST_RUN));
endmodule

// File: rtl/wkt_count.sv
module wkt_count #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             flag_clr,
    output logic             flag_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = run && tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // R3: count only moves on a counted tick or a load
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt_q));
    // R3: reaching zero on a tick raises the flag
    a_r3_zero_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_q == '0) |=> flag_q);
    // R9: flag sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R7: no new flag while stopped
    a_r7_no_set_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !$rose(flag_q));
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer #(
    parameter int RLD_W = 16,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic [2:0]       ctrl_sel,
    input  logic             ctrl_ie,
    input  logic             rld_we,
    input  logic [RLD_W-1:0] rld_wdata,
    input  logic             flag_clr,
    output logic [31:0]      rld_rdata,
    output logic [2:0]       sel_rdata,
    output logic             running,
    output logic             wr_ok,
    output logic             wake_flag,
    output logic             irq
);
    import wkt_pkg::*;

    localparam int CNT_W = RLD_W + 1;

    logic             tick, ie_q, load;
    logic [2:0]       sel_q;
    logic [RLD_W-1:0] rld_q;
    logic [CNT_W-1:0] load_val, reload_val;

    wkt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .sec_tick(sec_tick), .tick(tick)
    );

    wkt_ctrl #(.RLD_W(RLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_sel(ctrl_sel), .ctrl_ie(ctrl_ie),
        .rld_we(rld_we), .rld_wdata(rld_wdata),
        .sel_q(sel_q), .ie_q(ie_q), .rld_q(rld_q),
        .run(running), .wr_ok(wr_ok), .load(load),
        .load_val(load_val), .reload_val(reload_val)
    );

    wkt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(running), .load(load),
        .load_val(load_val), .reload_val(reload_val),
        .flag_clr(flag_clr), .flag_q(wake_flag)
    );

    assign rld_rdata = {{(RDATA_W-RLD_W){1'b0}}, rld_q};
    assign sel_rdata = sel_q;
    assign irq       = wake_flag & ie_q;

    // R10: interrupt never without the flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake_flag);
    // R6: not writable while running
    a_r6_locked_running: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !wr_ok);
endmodule

// File: tb/wkup_timer_tb.sv
module wkup_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        ctrl_we = 1'b0, ctrl_en = 1'b0, ctrl_ie = 1'b0;
    logic [2:0]  ctrl_sel = 3'b000;
    logic        rld_we = 1'b0;
    logic [15:0] rld_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] rld_rdata;
    logic [2:0]  sel_rdata;
    logic        running, wr_ok, wake_flag, irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    wkup_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_sel(ctrl_sel), .ctrl_ie(ctrl_ie),
        .rld_we(rld_we), .rld_wdata(rld_wdata), .flag_clr(flag_clr),
        .rld_rdata(rld_rdata), .sel_rdata(sel_rdata), .running(running),
        .wr_ok(wr_ok), .wake_flag(wake_flag), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        wait (cycles > 190000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ctrl_wr(logic en, logic [2:0] sel, logic ie);
        ctrl_we = 1'b1; ctrl_en = en; ctrl_sel = sel; ctrl_ie = ie;
        step();
        ctrl_we = 1'b0;
    endtask

    task automatic rld_wr(logic [15:0] v);
        rld_we = 1'b1; rld_wdata = v;
        step();
        rld_we = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; step();
            sec_tick = 1'b0; step();
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    // stop, return to IDLE, select 000, clear flag
    task automatic stop_all();
        ctrl_wr(1'b0, 3'b000, 1'b0);
        sec_tick = 1'b1;
        for (int i = 0; i < 40 && !wr_ok; i++) step();
        sec_tick = 1'b0;
        ctrl_wr(1'b0, 3'b000, 1'b0);
        clear_flag();
    endtask

    task automatic measure(logic [2:0] sel, int r);
        int hits = 0;
        int last = 0;
        int period = (r + 1) * (16 >> sel);
        stop_all();
        rld_wr(16'(r));
        ctrl_wr(1'b1, sel, 1'b0);
        for (int n = 0; n < 6 * period + 20 && hits < 4; n++) begin
            step();
            flag_clr = 1'b0;
            if (wake_flag) begin
                if (hits > 0) chk($sformatf("R2 R3 sel=%0d r=%0d", sel, r), n - last, period);
                last = n;
                hits++;
                flag_clr = 1'b1;
            end
        end
        flag_clr = 1'b0;
        chk("R3 flag count", hits, 4);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 reload", int'(rld_rdata), 32'h0000FFFF);
        chk("R1 sel", int'(sel_rdata), 0);
        chk("R1 running", int'(running), 0);
        chk("R1 wr_ok", int'(wr_ok), 1);
        chk("R1 flag", int'(wake_flag), 0);
        chk("R1 irq", int'(irq), 0);

        // R8 refused pairing
        rld_wr(16'h0000);
        chk("R8 zero reload under sel000", int'(rld_rdata), 0);
        ctrl_wr(1'b0, 3'b011, 1'b0);
        chk("R8 sel011 refused with reload 0", int'(sel_rdata), 0);
        rld_wr(16'h0005);
        ctrl_wr(1'b0, 3'b011, 1'b0);
        chk("R8 sel011 accepted", int'(sel_rdata), 3);
        rld_wr(16'h0000);
        chk("R8 zero reload refused", int'(rld_rdata), 5);

        // R2 R3 sweep over clock-divided selects
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 4; r++)
                if (!(s == 3 && r == 0)) measure(3'(s), r);

        // R4 first flag in once-per-second mode, tick in enable cycle ignored
        stop_all();
        rld_wr(16'd4);
        sec_tick = 1'b1;
        ctrl_wr(1'b1, 3'b100, 1'b0);
        sec_tick = 1'b0;
        chk("R6 wr_ok low after enable", int'(wr_ok), 0);
        chk("R6 running", int'(running), 1);
        ticks(4);
        chk("R4 no flag after reload ticks", int'(wake_flag), 0);
        ticks(1);
        chk("R4 flag after reload+1 ticks", int'(wake_flag), 1);
        clear_flag();
        chk("R9 clear", int'(wake_flag), 0);
        ticks(4);
        chk("R3 sec mode no early flag", int'(wake_flag), 0);
        ticks(1);
        chk("R3 sec mode period", int'(wake_flag), 1);
        clear_flag();

        // R6 reload write while locked
        rld_wr(16'd7);
        chk("R6 locked reload", int'(rld_rdata), 4);
        // R7 select change while running ignored; R10 ie any time
        ctrl_wr(1'b1, 3'b000, 1'b1);
        chk("R7 sel unchanged while running", int'(sel_rdata), 4);
        chk("R10 irq flag low", int'(irq), 0);
        ticks(5);
        chk("R10 irq with flag", int'(irq), 1);
        ctrl_wr(1'b1, 3'b100, 1'b0);
        chk("R10 irq masked", int'(irq), 0);
        chk("R10 flag kept", int'(wake_flag), 1);
        clear_flag();

        // R7 disable and drain
        ticks(2);
        ctrl_wr(1'b0, 3'b100, 1'b0);
        chk("R7 stopped", int'(running), 0);
        chk("R7 still locked", int'(wr_ok), 0);
        step();
        chk("R7 locked without tick", int'(wr_ok), 0);
        ctrl_wr(1'b1, 3'b100, 1'b0);
        chk("R7 enable in drain ignored", int'(running), 0);
        sec_tick = 1'b1; step(); sec_tick = 1'b0;
        chk("R7 unlocked after tick", int'(wr_ok), 1);
        chk("R7 not running", int'(running), 0);
        ticks(10);
        chk("R7 no flag while stopped", int'(wake_flag), 0);

        // R9 set wins over clear
        rld_wr(16'd0);
        ctrl_wr(1'b1, 3'b100, 1'b0);
        ticks(1);
        chk("R9 flag set r=0", int'(wake_flag), 1);
        sec_tick = 1'b1; flag_clr = 1'b1; step();
        sec_tick = 1'b0; flag_clr = 1'b0;
        chk("R9 set wins", int'(wake_flag), 1);
        clear_flag();
        chk("R9 cleared", int'(wake_flag), 0);

        // R5 17-bit extension
        stop_all();
        rld_wr(16'd2);
        ctrl_wr(1'b1, 3'b100, 1'b0);
        sec_tick = 1'b1;
        repeat (2) step();
        chk("R5 16-bit no flag", int'(wake_flag), 0);
        step();
        chk("R5 16-bit flag at 3", int'(wake_flag), 1);
        stop_all();
        rld_wr(16'd2);
        ctrl_wr(1'b1, 3'b110, 1'b0);
        sec_tick = 1'b1;
        for (int i = 0; i < 65538; i++) step();
        chk("R5 17-bit no flag", int'(wake_flag), 0);
        step();
        chk("R5 17-bit flag at 65539", int'(wake_flag), 1);
        sec_tick = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule